// File: doc/BRIEF.md
# Display Register Window Decoder

The block sits behind the memory-mapped register window of a display adapter and steers every bus access to one of four subregions. The first is a read-only 256-byte monitor identification ROM at the bottom of the window. The second is a remap of the legacy byte-wide display I/O ports. The third is an indexed mode-setting register file, reached through an index-load cycle followed by a data cycle. The fourth is a small extended bank that reports its own size and holds the framebuffer byte-order flag. Any other address is unmapped.

A bus access is a single-cycle `rd_i` or `wr_i` strobe with address, write data and a size code (0 = byte, 1 = 16-bit, 2 = 32-bit). The block registers the access and works through one or two downstream cycles. It then raises `done_o` for one cycle, and on a read `rdata_o` carries the result. A 16-bit access to the legacy ports becomes two byte cycles on consecutive ports, low byte first. An indexed access loads the index, which is the window offset divided by two, and then moves the data. The byte-order flag changes only when an exact magic word is written.

Top module: `disp_win_dec`

## Requirements
- R1: After reset `done_o`, `be_o`, `rdata_o` and all downstream strobes are 0.
- R2: An access that needs one downstream step raises `done_o` for exactly one cycle, two clock edges after the edge that samples the strobe. A split access does the same three edges after. Strobes that arrive while an access is in progress are ignored. A completed write returns `rdata_o` = 0.
- R3: A byte access at legacy offset `k` (window 0x400..0x41F) makes one request to port 0x3C0+k. A read returns the port byte in bits 7:0 with the upper bits zero.
- R4: A 16-bit or 32-bit access at legacy offset `k` makes two requests in consecutive cycles: port 0x3C0+k with data bits 7:0, then port 0x3C1+k with bits 15:8. A read returns {port k+1, port k} in bits 15:0 with the upper bits zero.
- R5: An access at indexed offset `k` (window 0x500..0x515) first pulses `ix_load_o` with `ix_index_o` = k>>1. In the next cycle it pulses `ix_rd_o` or `ix_wr_o`. A read returns `ix_rdata_i` zero-extended.
- R6: A 32-bit read of extended offset 0 (window 0x600) returns the bank size, 8.
- R7: A 32-bit read of extended offset 4 (window 0x604) returns 0xBEBEBEBE when `be_o` is 1 and 0x1E1E1E1E when it is 0.
- R8: A 32-bit write of exactly 0xBEBEBEBE to offset 4 sets `be_o`, and one of exactly 0x1E1E1E1E clears it. Any other value, and any 8- or 16-bit access to the bank, leaves `be_o` unchanged. Such narrow reads return 0.
- R9: Reads of other extended offsets return 0, and writes to them leave `be_o` unchanged.
- R10: The ROM at window 0x000..0x0FF holds these bytes: byte 0 and byte 7 are 0x00, bytes 1..6 are 0xFF, byte i for 8..254 is (7·i+3) mod 256, and byte 255 makes the sum of all 256 bytes 0 mod 256. Multi-byte reads are little-endian. Writes do not change the ROM.
- R11: Reads of unmapped addresses return 0. Writes to them cause no downstream request.
- R12: `rev_o` is 2 when the extended bank is enabled and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Window byte address |
| wdata_i | input | 32 | Write data |
| size_i | input | 2 | Access size: 0 byte, 1 16-bit, 2 32-bit |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Read data, valid with done_o |
| done_o | output | 1 | One-cycle completion pulse |
| lp_req_o | output | 1 | Legacy port request |
| lp_we_o | output | 1 | Legacy port request is a write |
| lp_port_o | output | 16 | Legacy port number |
| lp_wdata_o | output | 8 | Legacy port write byte |
| lp_rdata_i | input | 8 | Legacy port read byte, same cycle |
| ix_load_o | output | 1 | Index load strobe |
| ix_index_o | output | IDX_W | Register index |
| ix_rd_o | output | 1 | Indexed data read strobe |
| ix_wr_o | output | 1 | Indexed data write strobe |
| ix_wdata_o | output | 16 | Indexed write data |
| ix_rdata_i | input | 16 | Indexed read data, same cycle |
| be_o | output | 1 | Framebuffer big-endian flag |
| rev_o | output | 8 | Reported device revision |

## Verification
The bench attacks the split cycles. A strobe is sent into the middle of a 16-bit legacy write, and the bench checks the downstream port order and the byte lanes. A decoder that swapped the halves, repeated a port or accepted the second strobe would show up in the port log. For the byte-order flag the bench tries near-miss magic values and narrow accesses. Loose matching or a missing size check would flip `be_o`. Indexed reads follow writes to the same index, so an index that is not halved or a data cycle ahead of the load returns the wrong word. The bench also sums the whole ROM to zero and reads the checksum byte, which exposes a wrong lane order or a bad checksum.

// File: rtl/disp_win_pkg.sv
package disp_win_pkg;

  typedef enum logic [2:0] {RG_NONE, RG_ROM, RG_LEG, RG_IDX, RG_EXT} region_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ONE, ST_TWO, ST_DONE} state_e;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  localparam int unsigned ROM_BYTES = 256;
  localparam int unsigned EXT_OFF_SIZE = 0;
  localparam int unsigned EXT_OFF_ORDER = 4;

  function automatic logic [7:0] rom_body(logic [7:0] i);
    if (i == 8'd0 || i == 8'd7) return 8'h00;
    if (i < 8'd7) return 8'hFF;
    return 8'(i * 8'd7 + 8'd3);
  endfunction

  function automatic logic [7:0] rom_csum();
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < 255; i++) s = s + rom_body(8'(i));
    return 8'h00 - s;
  endfunction

endpackage

// File: rtl/disp_win_decode.sv
module disp_win_decode
  import disp_win_pkg::*;
#(
  parameter int unsigned AW       = 12,
  parameter bit          ROM_EN   = 1'b1,
  parameter bit          EXT_EN   = 1'b1,
  parameter int unsigned ROM_BASE = 32'h000,
  parameter int unsigned LEG_BASE = 32'h400,
  parameter int unsigned LEG_SIZE = 32'h20,
  parameter int unsigned IDX_BASE = 32'h500,
  parameter int unsigned IDX_SIZE = 32'h16,
  parameter int unsigned EXT_BASE = 32'h600,
  parameter int unsigned EXT_SIZE = 32'h8
) (
  input  logic [AW-1:0] addr_i,
  output region_e       region_o,
  output logic [AW-1:0] off_o
);

  logic [31:0] a;
  assign a = 32'(addr_i);

  always_comb begin
    region_o = RG_NONE;
    off_o    = '0;
    if (ROM_EN && a >= ROM_BASE && a < ROM_BASE + ROM_BYTES) begin
      region_o = RG_ROM;
      off_o    = AW'(a - ROM_BASE);
    end else if (a >= LEG_BASE && a < LEG_BASE + LEG_SIZE) begin
      region_o = RG_LEG;
      off_o    = AW'(a - LEG_BASE);
    end else if (a >= IDX_BASE && a < IDX_BASE + IDX_SIZE) begin
      region_o = RG_IDX;
      off_o    = AW'(a - IDX_BASE);
    end else if (EXT_EN && a >= EXT_BASE && a < EXT_BASE + EXT_SIZE) begin
      region_o = RG_EXT;
      off_o    = AW'(a - EXT_BASE);
    end
  end

endmodule

// File: rtl/disp_win_ext.sv
module disp_win_ext
  import disp_win_pkg::*;
#(
  parameter int unsigned EXT_SIZE = 8,
  parameter logic [31:0] MAGIC_BE = 32'hBEBEBEBE,
  parameter logic [31:0] MAGIC_LE = 32'h1E1E1E1E,
  localparam int unsigned OFF_W   = (EXT_SIZE > 1) ? $clog2(EXT_SIZE) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  output logic             be_o
);

  logic be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) be_q <= 1'b0;
    else if (we_i && 32'(off_i) == EXT_OFF_ORDER) begin
      if (wdata_i == MAGIC_BE)      be_q <= 1'b1;
      else if (wdata_i == MAGIC_LE) be_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (32'(off_i) == EXT_OFF_SIZE)       rdata_o = 32'(EXT_SIZE);
    else if (32'(off_i) == EXT_OFF_ORDER) rdata_o = be_q ? MAGIC_BE : MAGIC_LE;
  end

  assign be_o = be_q;

endmodule

// File: rtl/disp_win_rom.sv
module disp_win_rom
  import disp_win_pkg::*;
(
  input  logic [7:0]  off_i,
  input  logic [1:0]  size_i,
  output logic [31:0] rdata_o
);

  localparam logic [7:0] CSUM = rom_csum();

  logic [2:0] nbytes;
  assign nbytes = (size_i == SZ_BYTE) ? 3'd1 : (size_i == SZ_HALF) ? 3'd2 : 3'd4;

  for (genvar k = 0; k < 4; k++) begin : g_lane
    logic [8:0] idx;
    logic [7:0] val;
    assign idx = 9'(off_i) + 9'(k);
    always_comb begin
      val = 8'h00;
      if (3'(k) < nbytes && !idx[8])
        val = (idx[7:0] == 8'hFF) ? CSUM : rom_body(idx[7:0]);
    end
    assign rdata_o[8*k +: 8] = val;
  end

endmodule

// File: rtl/disp_win_dec.sv
module disp_win_dec
  import disp_win_pkg::*;
#(
  parameter int unsigned AW       = 12,
  parameter int unsigned IDX_W    = 8,
  parameter bit          ROM_EN   = 1'b1,
  parameter bit          EXT_EN   = 1'b1,
  parameter int unsigned LEG_PORT = 32'h3C0,
  parameter int unsigned LEG_BASE = 32'h400,
  parameter int unsigned LEG_SIZE = 32'h20,
  parameter int unsigned IDX_BASE = 32'h500,
  parameter int unsigned IDX_SIZE = 32'h16,
  parameter int unsigned EXT_BASE = 32'h600,
  parameter int unsigned EXT_SIZE = 32'h8,
  parameter logic [31:0] MAGIC_BE = 32'hBEBEBEBE,
  parameter logic [31:0] MAGIC_LE = 32'h1E1E1E1E
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic [31:0]      wdata_i,
  input  logic [1:0]       size_i,
  input  logic             rd_i,
  input  logic             wr_i,
  output logic [31:0]      rdata_o,
  output logic             done_o,
  output logic             lp_req_o,
  output logic             lp_we_o,
  output logic [15:0]      lp_port_o,
  output logic [7:0]       lp_wdata_o,
  input  logic [7:0]       lp_rdata_i,
  output logic             ix_load_o,
  output logic [IDX_W-1:0] ix_index_o,
  output logic             ix_rd_o,
  output logic             ix_wr_o,
  output logic [15:0]      ix_wdata_o,
  input  logic [15:0]      ix_rdata_i,
  output logic             be_o,
  output logic [7:0]       rev_o
);

  localparam int unsigned EXT_OW = (EXT_SIZE > 1) ? $clog2(EXT_SIZE) : 1;

  state_e        st_q, st_d;
  region_e       rg_d, rg_q;
  logic [AW-1:0] off_d, off_q;
  logic [1:0]    sz_q;
  logic [31:0]   wd_q;
  logic          wr_q;
  logic [31:0]   rdata_q, rdata_d;
  logic [31:0]   ext_rdata, rom_rdata;
  logic          ext_we;
  logic          sz_word;

  disp_win_decode #(
    .AW(AW), .ROM_EN(ROM_EN), .EXT_EN(EXT_EN), .ROM_BASE(32'h000),
    .LEG_BASE(LEG_BASE), .LEG_SIZE(LEG_SIZE), .IDX_BASE(IDX_BASE),
    .IDX_SIZE(IDX_SIZE), .EXT_BASE(EXT_BASE), .EXT_SIZE(EXT_SIZE)
  ) u_decode (
    .addr_i(addr_i), .region_o(rg_d), .off_o(off_d)
  );

  disp_win_ext #(
    .EXT_SIZE(EXT_SIZE), .MAGIC_BE(MAGIC_BE), .MAGIC_LE(MAGIC_LE)
  ) u_ext (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(ext_we), .off_i(off_q[EXT_OW-1:0]),
    .wdata_i(wd_q), .rdata_o(ext_rdata), .be_o(be_o)
  );

  disp_win_rom u_rom (
    .off_i(off_q[7:0]), .size_i(sz_q), .rdata_o(rom_rdata)
  );

  assign sz_word = (sz_q == SZ_WORD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      rg_q    <= RG_NONE;
      off_q   <= '0;
      sz_q    <= SZ_BYTE;
      wd_q    <= '0;
      wr_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      st_q    <= st_d;
      rdata_q <= rdata_d;
      if (st_q == ST_IDLE && (rd_i || wr_i)) begin
        rg_q  <= rg_d;
        off_q <= off_d;
        sz_q  <= size_i;
        wd_q  <= wdata_i;
        wr_q  <= wr_i;
      end
    end
  end

  // next state and read-data capture
  always_comb begin
    st_d    = st_q;
    rdata_d = rdata_q;
    unique case (st_q)
      ST_IDLE: if (rd_i || wr_i) begin
        st_d    = ST_ONE;
        rdata_d = '0;
      end
      ST_ONE: begin
        st_d = ST_DONE;
        unique case (rg_q)
          RG_LEG: begin
            if (!wr_q) rdata_d[7:0] = lp_rdata_i;
            if (sz_q != SZ_BYTE) st_d = ST_TWO;
          end
          RG_IDX: st_d = ST_TWO;
          RG_EXT: if (!wr_q && sz_word) rdata_d = ext_rdata;
          RG_ROM: if (!wr_q) rdata_d = rom_rdata;
          default: ;
        endcase
      end
      ST_TWO: begin
        st_d = ST_DONE;
        if (!wr_q) begin
          if (rg_q == RG_LEG)      rdata_d[15:8] = lp_rdata_i;
          else if (rg_q == RG_IDX) rdata_d = {16'h0000, ix_rdata_i};
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // downstream strobes
  always_comb begin
    lp_req_o   = 1'b0;
    lp_we_o    = 1'b0;
    lp_port_o  = 16'(LEG_PORT) + 16'(off_q);
    lp_wdata_o = wd_q[7:0];
    ix_load_o  = 1'b0;
    ix_rd_o    = 1'b0;
    ix_wr_o    = 1'b0;
    ext_we     = 1'b0;
    if (st_q == ST_ONE) begin
      unique case (rg_q)
        RG_LEG: begin
          lp_req_o = 1'b1;
          lp_we_o  = wr_q;
        end
        RG_IDX: ix_load_o = 1'b1;
        RG_EXT: ext_we = wr_q && sz_word;
        default: ;
      endcase
    end else if (st_q == ST_TWO) begin
      if (rg_q == RG_LEG) begin
        lp_req_o   = 1'b1;
        lp_we_o    = wr_q;
        lp_port_o  = 16'(LEG_PORT) + 16'(off_q) + 16'd1;
        lp_wdata_o = wd_q[15:8];
      end else if (rg_q == RG_IDX) begin
        ix_rd_o = !wr_q;
        ix_wr_o = wr_q;
      end
    end
  end

  assign ix_index_o = IDX_W'(off_q >> 1);
  assign ix_wdata_o = wd_q[15:0];
  assign rdata_o    = rdata_q;
  assign done_o     = (st_q == ST_DONE);
  assign rev_o      = EXT_EN ? 8'd2 : 8'd1;

endmodule

// File: rtl/disp_win_chk.sv
module disp_win_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        done_o,
  input logic [31:0] rdata_o,
  input logic        wr_q,
  input logic        lp_req_o,
  input logic [15:0] lp_port_o,
  input logic        ix_load_o,
  input logic        ix_rd_o,
  input logic        ix_wr_o,
  input logic        ext_we,
  input logic        be_o
);

  p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_wr_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && wr_q) |-> rdata_o == 32'h0);

  p_port_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_req_o && $past(lp_req_o)) |-> lp_port_o == $past(lp_port_o) + 16'd1);

  p_load_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ix_rd_o || ix_wr_o) |-> $past(ix_load_o));

  p_flag_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (be_o != $past(be_o)) |-> $past(ext_we));

  p_one_target_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lp_req_o, ix_load_o, ix_rd_o || ix_wr_o}));

endmodule

bind disp_win_dec disp_win_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_o(done_o), .rdata_o(rdata_o),
  .wr_q(wr_q), .lp_req_o(lp_req_o), .lp_port_o(lp_port_o),
  .ix_load_o(ix_load_o), .ix_rd_o(ix_rd_o), .ix_wr_o(ix_wr_o),
  .ext_we(ext_we), .be_o(be_o)
);

// File: tb/disp_win_dec_bench.sv
module disp_win_dec_bench;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [1:0]  size_i = '0;
  logic        rd_i = 1'b0, wr_i = 1'b0;
  logic [31:0] rdata_o;
  logic        done_o, lp_req_o, lp_we_o, ix_load_o, ix_rd_o, ix_wr_o, be_o;
  logic [15:0] lp_port_o, ix_wdata_o;
  logic [7:0]  lp_wdata_o, lp_rdata_i, ix_index_o, rev_o;
  logic [15:0] ix_rdata_i;

  always #2 clk_i = ~clk_i;

  disp_win_dec u_disp_win_dec (.*);

  // downstream models
  logic [7:0]  lp_mem [64];
  logic [15:0] ix_mem [16];
  logic [7:0]  cur_idx;
  int          lg_port[$], lg_data[$], lg_we[$];
  int          ix_loads = 0;

  initial begin
    for (int k = 0; k < 64; k++) lp_mem[k] = 8'(8'hA0 + k);
    for (int k = 0; k < 16; k++) ix_mem[k] = 16'(16'h1000 + k * 16'h111);
    cur_idx = '0;
  end

  assign lp_rdata_i = lp_mem[lp_port_o[5:0]];
  assign ix_rdata_i = ix_mem[cur_idx[3:0]];

  always @(posedge clk_i) begin
    if (lp_req_o) begin
      lg_port.push_back(int'(lp_port_o));
      lg_data.push_back(int'(lp_wdata_o));
      lg_we.push_back(int'(lp_we_o));
      if (lp_we_o) lp_mem[lp_port_o[5:0]] <= lp_wdata_o;
    end
    if (ix_load_o) begin
      cur_idx  <= ix_index_o;
      ix_loads <= ix_loads + 1;
    end
    if (ix_wr_o) ix_mem[cur_idx[3:0]] <= ix_wdata_o;
  end

  // scoreboard
  typedef struct {logic [31:0] d; int lat; int launch; string tag;} item_t;
  item_t sb[$];
  int cyc = 0, n_chk = 0, n_bad = 0;
  logic [31:0] last_rd;
  bit finished = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) if (rst_ni && done_o) begin
    if (sb.size() == 0) chk(0, "R2 unexpected done", 32'(done_o), 32'h0);
    else begin
      item_t it;
      it = sb.pop_front();
      last_rd = rdata_o;
      chk(rdata_o == it.d, it.tag, rdata_o, it.d);
      chk(cyc - it.launch == it.lat, {it.tag, " R2 latency"}, 32'(cyc - it.launch), 32'(it.lat));
    end
  end

  task automatic acc(input logic [11:0] a, input logic [1:0] sz, input bit w,
                     input logic [31:0] d, input logic [31:0] exp, input int lat, input string tag);
    item_t it;
    @(negedge clk_i);
    addr_i = a; size_i = sz; wdata_i = d; rd_i = !w; wr_i = w;
    it.d = exp; it.lat = lat; it.launch = cyc; it.tag = tag;
    sb.push_back(it);
    @(negedge clk_i);
    rd_i = 0; wr_i = 0;
    wait (sb.size() == 0);
    @(negedge clk_i);
  endtask

  function automatic logic [7:0] rom_exp(int i);
    int s;
    if (i == 255) begin
      s = 0;
      for (int j = 0; j < 255; j++) s += int'(rom_exp(j));
      return 8'((256 - (s % 256)) % 256);
    end
    if (i == 0 || i == 7) return 8'h00;
    if (i < 7) return 8'hFF;
    return 8'((7 * i + 3) % 256);
  endfunction

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      chk(0, "watchdog", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int s;
    repeat (3) @(negedge clk_i);
    // R1
    chk(done_o == 0 && lp_req_o == 0 && ix_load_o == 0 && ix_rd_o == 0 && ix_wr_o == 0,
        "R1 strobes", {28'h0, done_o, lp_req_o, ix_load_o, ix_wr_o}, 32'h0);
    chk(be_o == 0 && rdata_o == 0, "R1 flag/rdata", rdata_o, 32'h0);
    rst_ni = 1;
    @(negedge clk_i);
    // R12
    chk(rev_o == 8'd2, "R12 revision", 32'(rev_o), 32'd2);
    // R6 R7
    acc(12'h600, 2'd2, 0, 0, 32'd8, 2, "R6 size reg");
    acc(12'h604, 2'd2, 0, 0, 32'h1E1E1E1E, 2, "R7 order LE");
    // R8
    acc(12'h604, 2'd2, 1, 32'hBEBEBEBE, 0, 2, "R8 write BE");
    chk(be_o == 1, "R8 be set", 32'(be_o), 32'd1);
    acc(12'h604, 2'd2, 0, 0, 32'hBEBEBEBE, 2, "R7 order BE");
    acc(12'h604, 2'd2, 1, 32'h1E1E1E1F, 0, 2, "R8 near miss");
    chk(be_o == 1, "R8 near miss ignored", 32'(be_o), 32'd1);
    acc(12'h604, 2'd1, 1, 32'h1E1E1E1E, 0, 2, "R8 half write");
    chk(be_o == 1, "R8 half write ignored", 32'(be_o), 32'd1);
    acc(12'h604, 2'd1, 0, 0, 32'h0, 2, "R8 half read zero");
    // R9
    acc(12'h602, 2'd2, 1, 32'h1E1E1E1E, 0, 2, "R9 unused write");
    chk(be_o == 1, "R9 unused write ignored", 32'(be_o), 32'd1);
    acc(12'h602, 2'd2, 0, 0, 32'h0, 2, "R9 unused read");
    acc(12'h604, 2'd2, 1, 32'h1E1E1E1E, 0, 2, "R8 write LE");
    chk(be_o == 0, "R8 be cleared", 32'(be_o), 32'd0);
    // R3
    lg_port.delete(); lg_data.delete(); lg_we.delete();
    acc(12'h405, 2'd0, 0, 0, 32'h000000A5, 2, "R3 byte read");
    chk(lg_port.size() == 1 && lg_port[0] == 'h3C5 && lg_we[0] == 0, "R3 read port",
        32'(lg_port[0]), 32'h3C5);
    lg_port.delete(); lg_data.delete(); lg_we.delete();
    acc(12'h401, 2'd0, 1, 32'h77, 0, 2, "R3 byte write");
    chk(lg_port.size() == 1 && lg_port[0] == 'h3C1 && lg_data[0] == 'h77, "R3 write port",
        32'(lg_port[0]), 32'h3C1);
    // R4 split write with a strobe while busy (R2)
    lg_port.delete(); lg_data.delete(); lg_we.delete();
    begin
      item_t it;
      @(negedge clk_i);
      addr_i = 12'h402; size_i = 2'd1; wdata_i = 32'h1234; wr_i = 1;
      it.d = 0; it.lat = 3; it.launch = cyc; it.tag = "R4 half write";
      sb.push_back(it);
      @(negedge clk_i);
      addr_i = 12'h408; wdata_i = 32'h9999;
      @(negedge clk_i);
      wr_i = 0;
      wait (sb.size() == 0);
      repeat (3) @(negedge clk_i);
    end
    chk(lg_port.size() == 2, "R2 busy strobe ignored", 32'(lg_port.size()), 32'd2);
    chk(lg_port[0] == 'h3C2 && lg_data[0] == 'h34, "R4 low byte first",
        32'((lg_port[0] << 8) | lg_data[0]), 32'h3C234);
    chk(lg_port[1] == 'h3C3 && lg_data[1] == 'h12, "R4 high byte second",
        32'((lg_port[1] << 8) | lg_data[1]), 32'h3C312);
    acc(12'h402, 2'd1, 0, 0, 32'h00001234, 3, "R4 half read");
    acc(12'h402, 2'd2, 0, 0, 32'h00001234, 3, "R4 word read");
    // R5
    acc(12'h506, 2'd1, 1, 32'hCAFE, 0, 3, "R5 idx write");
    acc(12'h506, 2'd1, 0, 0, 32'h0000CAFE, 3, "R5 idx readback");
    acc(12'h50A, 2'd1, 0, 0, 32'h00001555, 3, "R5 idx 5 read");
    // R10
    acc(12'h000, 2'd0, 0, 0, 32'h0, 2, "R10 rom byte0");
    acc(12'h003, 2'd0, 0, 0, 32'hFF, 2, "R10 rom byte3");
    acc(12'h008, 2'd2, 0, 0, {rom_exp(11), rom_exp(10), rom_exp(9), rom_exp(8)}, 2, "R10 rom word");
    acc(12'h0FE, 2'd1, 0, 0, {16'h0, rom_exp(255), rom_exp(254)}, 2, "R10 rom csum half");
    acc(12'h010, 2'd0, 1, 32'h55, 0, 2, "R10 rom write");
    acc(12'h010, 2'd0, 0, 0, {24'h0, rom_exp(16)}, 2, "R10 rom after write");
    s = 0;
    for (int k = 0; k < 64; k++) begin
      acc(12'(4 * k), 2'd2, 0, 0, {rom_exp(4*k+3), rom_exp(4*k+2), rom_exp(4*k+1), rom_exp(4*k)}, 2, "R10 rom scan");
      s += int'(last_rd[7:0]) + int'(last_rd[15:8]) + int'(last_rd[23:16]) + int'(last_rd[31:24]);
    end
    chk(s % 256 == 0, "R10 rom sum", 32'(s % 256), 32'h0);
    // R11
    lg_port.delete(); lg_data.delete(); lg_we.delete();
    s = ix_loads;
    acc(12'h300, 2'd2, 0, 0, 32'h0, 2, "R11 unmapped read");
    acc(12'h300, 2'd2, 1, 32'hBEBEBEBE, 0, 2, "R11 unmapped write");
    chk(lg_port.size() == 0 && ix_loads == s && be_o == 0, "R11 no downstream",
        32'(lg_port.size()), 32'h0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule